// File: doc/BRIEF.md
# Dual-Protocol Host Register Interface

This block is a parallel slave port through which an 8-bit host processor configures and monitors a peripheral. A strap input picks the bus style. In strobe-and-direction style, one active-low strobe marks the transfer and a direction line tells read from write. In split-strobe style, two active-low strobes, one for reads and one for writes, share those same two pins. A second strap picks whether the address arrives on its own pins or on the low bits of the shared data bus, where a falling address-latch pulse captures it.

The block samples every bus control line with two flip-flops clocked by a free-running reference clock, so it works at any host bus speed. It decodes the cycle, drives the data bus only while a read is in progress, and answers on a handshake pin. In strobe-and-direction style the handshake falls when read data is valid or write data is accepted. In split-strobe style it is held low as a wait request and rises when the host may end the cycle. Twelve configuration registers drive the peripheral. A latched alarm status register with a mask drives an active-low interrupt.

Register map, using a 4-bit address: 0x0 is alarm status (each bit is cleared by writing 1). 0x1 is the interrupt mask. 0x2 to 0xD are the configuration registers; register 0x2+k appears on `cfg_out[8k+7:8k]`. 0xE shows the current synchronized alarm levels and is read-only. 0xF is unmapped.

Top module: `hbus_slave`

## Requirements
- R1: While reset is held and after it is released, `data_oe` is 0, `hs_out` is 1, `irq_n` is 1 and `cfg_out` is all zero.
- R2: In strobe-and-direction style (`mode_sel`=0), with `cs_n` low and `rw_rd` high, a falling `ds_wr` starts a read. `data_oe` rises 3 clocks after the strobe falls, with `data_out` showing the addressed register. It falls 3 clocks after the strobe rises.
- R3: In strobe-and-direction style, `hs_out` idles at 1. It goes to 0 five clocks after the strobe falls and returns to 1 three clocks after the strobe rises.
- R4: In strobe-and-direction style, with `rw_rd` low, the data on `data_in` is written into the addressed register when `ds_wr` rises. Writes to 0x2 to 0xD appear on `cfg_out`.
- R5: In split-strobe style (`mode_sel`=1), `rw_rd` low with `ds_wr` high is a read and `ds_wr` low with `rw_rd` high is a write, with the same 3-clock output timing as R2 and R4. Both strobes falling together start no cycle and change no register.
- R6: In split-strobe style, `hs_out` is 0 from 3 to 5 clocks after the strobe falls, then 1 until the cycle ends.
- R7: With `mux_sel`=1, a falling `as_ale` latches the address from `data_in[3:0]`, and the `addr` pins are ignored.
- R8: A strobe while `cs_n` is high starts no cycle: `data_oe` stays 0, `hs_out` stays 1 and no register changes.
- R9: Address 0xF reads as 0x00, and writes to it have no effect.
- R10: A rising alarm input sets its bit in status register 0x0. Writing 1 to a status bit clears it. Register 0xE reads the current alarm levels and ignores writes.
- R11: `irq_n` is 0 exactly when some status bit is set whose bit in mask register 0x1 is also 1. It falls 3 clocks after a masked alarm input rises.
- R12: `data_oe` is never 1 during a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic and for the handshake |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Bus style strap: 0 strobe-and-direction, 1 split strobes |
| mux_sel | input | 1 | 1: address is taken from the data bus on a falling `as_ale` |
| cs_n | input | 1 | Active-low chip select |
| rw_rd | input | 1 | Direction (1 read) in style 0; active-low read strobe in style 1 |
| ds_wr | input | 1 | Active-low data strobe in style 0; active-low write strobe in style 1 |
| as_ale | input | 1 | Active-low address latch pulse; held high when not multiplexed |
| addr | input | 4 | Address pins for the non-multiplexed bus |
| data_in | input | 8 | Data bus input side (carries the address in multiplexed mode) |
| data_out | output | 8 | Data bus output side; 0 when not driving |
| data_oe | output | 1 | Output enable of the bidirectional data bus |
| hs_out | output | 1 | Ready/acknowledge handshake |
| irq_n | output | 1 | Active-low interrupt |
| alarm_in | input | 8 | Alarm condition inputs from the peripheral |
| cfg_out | output | 96 | Twelve configuration registers, register 0x2 in the low byte |

## Verification
Every bus-side result goes through two synchronizer stages and one edge-detect register. So the bus output enable, the read data and the split-strobe wait request are due 3 clocks after the strobe edge that starts or ends a cycle, a register write takes effect 3 clocks after the strobe rises, and the interrupt follows an alarm edge after 3 clocks. The strobe-and-direction acknowledge and the wait-request release are due 2 clocks after that, 5 clocks after the strobe falls. Inputs change only on falling clock edges, and each task samples on the falling edge exactly that many clocks after the stimulus. The bench also checks the interrupt one clock early, to show it is not ahead of time, and checks ignored cycles both at the bus pins during the strobe and by reading the register back afterwards.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_WAIT = 2'd1,
    CYC_DONE = 2'd2
  } cyc_state_t;

  // register map anchors (offsets from address zero)
  localparam int ADR_STATUS = 0;
  localparam int ADR_MASK   = 1;
  localparam int ADR_CFG0   = 2;

endpackage

// File: rtl/hbus_rst_sync.sv
module hbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_sn  <= stage_q;
    end
  end

endmodule

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int               W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/hbus_cycle.sv
module hbus_cycle
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int HS_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              mux_sel,
  input  logic              s_cs_n,
  input  logic              s_rw_rd,
  input  logic              s_ds_wr,
  input  logic              s_as_ale,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              bus_oe,
  output logic              hs_out
);

  localparam int CNT_W = (HS_DLY < 2) ? 1 : $clog2(HS_DLY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HS_DLY - 1);

  cyc_state_t state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic act_q, as_q, rd_q;
  logic act_now, legal_now, rd_now, start_c, end_c, as_fall, busy;

  // strobe view that is common to both bus styles
  always_comb begin
    if (mode_sel) begin
      act_now   = !s_rw_rd || !s_ds_wr;
      legal_now = s_rw_rd ^ s_ds_wr;
      rd_now    = !s_rw_rd;
    end else begin
      act_now   = !s_ds_wr;
      legal_now = 1'b1;
      rd_now    = s_rw_rd;
    end
  end

  assign busy    = (state_q != CYC_IDLE);
  assign start_c = !busy && !s_cs_n && act_now && !act_q && legal_now;
  assign end_c   = !act_now || s_cs_n;
  assign as_fall = mux_sel && !s_as_ale && as_q;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      CYC_IDLE: begin
        if (start_c) begin
          state_d = CYC_WAIT;
          cnt_d   = '0;
        end
      end
      CYC_WAIT: begin
        if (end_c) begin
          state_d = CYC_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          state_d = CYC_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      CYC_DONE: begin
        if (end_c) state_d = CYC_IDLE;
      end
      default: state_d = CYC_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      as_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      act_q   <= act_now;
      as_q    <= s_as_ale;
    end
  end

  // cycle direction, captured at cycle start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
    end else if (start_c) begin
      rd_q <= rd_now;
    end
  end

  // address latch: address phase on the shared bus, or address pins at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
    end else if (as_fall) begin
      lat_addr <= s_data[ADDR_W-1:0];
    end else if (start_c && !mux_sel) begin
      lat_addr <= s_addr;
    end
  end

  // write commits when the strobe is released with the chip still selected
  assign wr_en   = busy && !rd_q && !act_now && !s_cs_n;
  assign wr_addr = lat_addr;
  assign wr_data = s_data;

  assign bus_oe  = busy && rd_q;
  assign hs_out  = mode_sel ? (state_q != CYC_WAIT) : (state_q != CYC_DONE);

endmodule

// File: rtl/hbus_regs.sv
module hbus_regs
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NALM   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic [NALM-1:0]          s_alarm,
  output logic [DATA_W-1:0]        rd_data,
  output logic [NALM-1:0]          alm_status,
  output logic                     irq_n,
  output logic [(2**ADDR_W-4)*DATA_W-1:0] cfg_out
);

  localparam int NCFG = 2**ADDR_W - 4;
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADR_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADR_MASK);
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(2**ADDR_W - 2);

  logic [DATA_W-1:0] cfg_q [NCFG];
  logic [NALM-1:0]   mask_q, alm_prev_q, status_d, alm_rise, alm_clr;

  // configuration registers
  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    logic sel_k;
    assign sel_k = wr_en && (wr_addr == ADDR_W'(ADR_CFG0 + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[k] <= '0;
      end else if (sel_k) begin
        cfg_q[k] <= wr_data;
      end
    end
    assign cfg_out[k*DATA_W +: DATA_W] = cfg_q[k];
  end

  // interrupt mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_en && (wr_addr == A_MASK)) begin
      mask_q <= wr_data[NALM-1:0];
    end
  end

  // alarm status: set on rising input, cleared by writing ones; set wins
  assign alm_rise = s_alarm & ~alm_prev_q;
  assign alm_clr  = (wr_en && (wr_addr == A_STATUS)) ? wr_data[NALM-1:0] : '0;
  assign status_d = (alm_status & ~alm_clr) | alm_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_prev_q <= '0;
      alm_status <= '0;
    end else begin
      alm_prev_q <= s_alarm;
      alm_status <= status_d;
    end
  end

  assign irq_n = !(|(alm_status & mask_q));

  // read multiplexer; the top address and anything unlisted read as zero
  always_comb begin
    rd_data = '0;
    if (rd_addr == A_STATUS) begin
      rd_data = DATA_W'(alm_status);
    end else if (rd_addr == A_MASK) begin
      rd_data = DATA_W'(mask_q);
    end else if (rd_addr == A_RAW) begin
      rd_data = DATA_W'(s_alarm);
    end else begin
      for (int k = 0; k < NCFG; k++) begin
        if (rd_addr == ADDR_W'(ADR_CFG0 + k)) rd_data = cfg_q[k];
      end
    end
  end

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NALM   = 8,
  parameter int HS_DLY = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            mode_sel,
  input  logic                            mux_sel,
  input  logic                            cs_n,
  input  logic                            rw_rd,
  input  logic                            ds_wr,
  input  logic                            as_ale,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               data_in,
  output logic [DATA_W-1:0]               data_out,
  output logic                            data_oe,
  output logic                            hs_out,
  output logic                            irq_n,
  input  logic [NALM-1:0]                 alarm_in,
  output logic [(2**ADDR_W-4)*DATA_W-1:0] cfg_out
);

  localparam int BUS_W = ADDR_W + DATA_W;

  logic              rst_sn;
  logic [3:0]        s_ctrl;
  logic [BUS_W-1:0]  s_bus;
  logic [NALM-1:0]   s_alarm;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, lat_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [NALM-1:0]   alm_status;
  logic              bus_oe;

  hbus_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  hbus_sync #(.W(4), .RST_VAL(4'hF)) u_sync_ctrl (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({cs_n, rw_rd, ds_wr, as_ale}),
    .q     (s_ctrl)
  );

  hbus_sync #(.W(BUS_W), .RST_VAL('0)) u_sync_bus (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({addr, data_in}),
    .q     (s_bus)
  );

  hbus_sync #(.W(NALM), .RST_VAL('0)) u_sync_alm (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (alarm_in),
    .q     (s_alarm)
  );

  hbus_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HS_DLY(HS_DLY)) u_cycle (
    .clk      (clk),
    .rst_n    (rst_sn),
    .mode_sel (mode_sel),
    .mux_sel  (mux_sel),
    .s_cs_n   (s_ctrl[3]),
    .s_rw_rd  (s_ctrl[2]),
    .s_ds_wr  (s_ctrl[1]),
    .s_as_ale (s_ctrl[0]),
    .s_addr   (s_bus[BUS_W-1:DATA_W]),
    .s_data   (s_bus[DATA_W-1:0]),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .lat_addr (lat_addr),
    .bus_oe   (bus_oe),
    .hs_out   (hs_out)
  );

  hbus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NALM(NALM)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sn),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (lat_addr),
    .s_alarm    (s_alarm),
    .rd_data    (rd_data),
    .alm_status (alm_status),
    .irq_n      (irq_n),
    .cfg_out    (cfg_out)
  );

  assign data_oe  = bus_oe;
  assign data_out = bus_oe ? rd_data : '0;

endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int NALM   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_sel,
  input logic              data_oe,
  input logic              hs_out,
  input logic [DATA_W-1:0] data_out,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic [NALM-1:0]   status
);

  // R12: no register write while the bus is driven
  a_r12_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !data_oe);

  // R6: split-strobe read starts with the wait request active
  a_r6_wait_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && $rose(data_oe)) |-> !hs_out);

  // R3: strobe-and-direction read starts before the acknowledge
  a_r3_ack_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && $rose(data_oe)) |-> hs_out);

  // R9: the unmapped address drives zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && (rd_addr == '1)) |-> (data_out == '0));

  // R10: status bits clear only through a write
  a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> (($past(status) & ~status) == '0));

endmodule

bind hbus_slave hbus_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NALM(NALM)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sn),
  .mode_sel (mode_sel),
  .data_oe  (data_oe),
  .hs_out   (hs_out),
  .data_out (data_out),
  .rd_addr  (lat_addr),
  .wr_en    (wr_en),
  .status   (alm_status)
);

// File: tb/hbus_slave_tb_top.sv
`timescale 1ns/1ps
module hbus_slave_tb_top;

  logic        clk;
  logic        rst_n;
  logic        mode_sel, mux_sel, cs_n, rw_rd, ds_wr, as_ale;
  logic [3:0]  addr;
  logic [7:0]  data_in, data_out, alarm_in;
  logic        data_oe, hs_out, irq_n;
  logic [95:0] cfg_out;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  hbus_slave dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .mux_sel  (mux_sel),
    .cs_n     (cs_n),
    .rw_rd    (rw_rd),
    .ds_wr    (ds_wr),
    .as_ale   (as_ale),
    .addr     (addr),
    .data_in  (data_in),
    .data_out (data_out),
    .data_oe  (data_oe),
    .hs_out   (hs_out),
    .irq_n    (irq_n),
    .alarm_in (alarm_in),
    .cfg_out  (cfg_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic nck(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // address phase on the shared bus; the address pins carry a wrong value
  task automatic mux_addr(input logic [3:0] a);
    data_in = {4'h0, a};
    addr    = ~a;
    as_ale  = 1'b0;
    nck(2);
    as_ale  = 1'b1;
    nck(1);
  endtask

  task automatic do_read(input logic [3:0] a, input logic [7:0] exp, input string tag);
    string hs_tag;
    hs_tag = mode_sel ? "R6" : "R3";
    if (mux_sel) begin
      mux_addr(a);
      data_in = 8'h00;
    end else begin
      addr = a;
    end
    cs_n  = 1'b0;
    rw_rd = 1'b1;
    nck(1);
    if (mode_sel) rw_rd = 1'b0; else ds_wr = 1'b0;
    nck(3);
    chk({tag, " oe"}, data_oe, 1'b1);
    chk({tag, " data"}, data_out, exp);
    chk({hs_tag, " hs start"}, hs_out, mode_sel ? 1'b0 : 1'b1);
    nck(2);
    chk({hs_tag, " hs after delay"}, hs_out, mode_sel ? 1'b1 : 1'b0);
    rw_rd = 1'b1;
    ds_wr = 1'b1;
    nck(3);
    chk({tag, " oe release"}, data_oe, 1'b0);
    chk({hs_tag, " hs idle"}, hs_out, 1'b1);
    cs_n = 1'b1;
    nck(2);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d);
    string hs_tag;
    hs_tag = mode_sel ? "R6" : "R3";
    if (mux_sel) mux_addr(a);
    else addr = a;
    data_in = d;
    cs_n    = 1'b0;
    rw_rd   = mode_sel ? 1'b1 : 1'b0;
    nck(1);
    ds_wr = 1'b0;
    nck(3);
    chk("R12 oe during write", data_oe, 1'b0);
    chk({hs_tag, " write hs start"}, hs_out, mode_sel ? 1'b0 : 1'b1);
    nck(2);
    chk({hs_tag, " write hs after delay"}, hs_out, mode_sel ? 1'b1 : 1'b0);
    ds_wr = 1'b1;
    nck(3);
    rw_rd = 1'b1;
    cs_n  = 1'b1;
    nck(2);
  endtask

  task automatic t_reset;
    chk("R1 oe", data_oe, 1'b0);
    chk("R1 hs", hs_out, 1'b1);
    chk("R1 irq", irq_n, 1'b1);
    chk("R1 cfg", cfg_out, 96'h0);
  endtask

  task automatic t_ds_basic;
    mode_sel = 1'b0; mux_sel = 1'b0;
    do_write(4'h2, 8'hA5);
    chk("R4 cfg low byte", cfg_out[7:0], 8'hA5);
    do_read(4'h2, 8'hA5, "R2");
    do_write(4'hD, 8'h3C);
    chk("R4 cfg top byte", cfg_out[95:88], 8'h3C);
    do_read(4'hD, 8'h3C, "R4");
  endtask

  task automatic t_unmapped;
    mode_sel = 1'b0; mux_sel = 1'b0;
    do_write(4'hF, 8'hFF);
    do_read(4'hF, 8'h00, "R9");
    chk("R9 cfg untouched", cfg_out, {8'h3C, 80'h0, 8'hA5});
  endtask

  task automatic t_no_select;
    mode_sel = 1'b0; mux_sel = 1'b0;
    cs_n = 1'b1; rw_rd = 1'b0; addr = 4'h2; data_in = 8'h5A;
    nck(1);
    ds_wr = 1'b0;
    nck(3);
    chk("R8 oe", data_oe, 1'b0);
    chk("R8 hs", hs_out, 1'b1);
    nck(3);
    ds_wr = 1'b1;
    nck(3);
    rw_rd = 1'b1;
    nck(2);
    chk("R8 cfg", cfg_out[7:0], 8'hA5);
    do_read(4'h2, 8'hA5, "R8");
  endtask

  task automatic t_split;
    mode_sel = 1'b1; mux_sel = 1'b0;
    do_write(4'h3, 8'hC3);
    chk("R5 cfg", cfg_out[15:8], 8'hC3);
    do_read(4'h3, 8'hC3, "R5");
    cs_n = 1'b0; addr = 4'h3; data_in = 8'h11;
    nck(1);
    rw_rd = 1'b0; ds_wr = 1'b0;
    nck(3);
    chk("R5 both low oe", data_oe, 1'b0);
    chk("R5 both low hs", hs_out, 1'b1);
    nck(3);
    rw_rd = 1'b1; ds_wr = 1'b1;
    nck(3);
    cs_n = 1'b1;
    nck(2);
    chk("R5 both low cfg", cfg_out[15:8], 8'hC3);
  endtask

  task automatic t_mux;
    mode_sel = 1'b0; mux_sel = 1'b1;
    do_write(4'h4, 8'h77);
    chk("R7 cfg", cfg_out[23:16], 8'h77);
    chk("R7 pin address unused", cfg_out[95:88], 8'h3C);
    do_read(4'h4, 8'h77, "R7");
    mode_sel = 1'b1;
    do_read(4'h4, 8'h77, "R7");
    mux_sel = 1'b0;
  endtask

  task automatic t_alarm;
    mode_sel = 1'b0; mux_sel = 1'b0;
    do_write(4'h1, 8'h01);
    do_read(4'h1, 8'h01, "R11");
    chk("R11 irq before alarm", irq_n, 1'b1);
    alarm_in = 8'h03;
    nck(2);
    chk("R11 irq not early", irq_n, 1'b1);
    nck(1);
    chk("R11 irq asserted", irq_n, 1'b0);
    do_read(4'h0, 8'h03, "R10");
    do_read(4'hE, 8'h03, "R10");
    do_write(4'h0, 8'h01);
    chk("R11 irq cleared", irq_n, 1'b1);
    do_read(4'h0, 8'h02, "R10");
    do_write(4'hE, 8'hFF);
    do_read(4'hE, 8'h03, "R10");
    alarm_in = 8'h00;
    nck(4);
    do_read(4'h0, 8'h02, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode_sel = 1'b0; mux_sel = 1'b0;
    cs_n = 1'b1; rw_rd = 1'b1; ds_wr = 1'b1; as_ale = 1'b1;
    addr = 4'h0; data_in = 8'h00; alarm_in = 8'h00;
    nck(3);
    t_reset();
    rst_n = 1'b1;
    nck(6);
    t_reset();
    t_ds_basic();
    t_unmapped();
    t_no_select();
    t_split();
    t_mux();
    t_alarm();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule